// File: doc/BRIEF.md
# Answer-to-Reset Byte Stream Parser

This block sits behind a character receiver on a smart-card interface and interprets the answer a card sends after reset. Each received character arrives as one raw byte with a single-cycle strobe. The raw byte uses the line coding: the first bit received is bit 0, and a high line level is 1. The first byte fixes the coding convention. Every later byte is decoded with that convention before it is interpreted. Under the inverse convention, decoding complements the byte and reverses its bit order.

After the convention byte, the parser follows the variable-length chain of interface bytes. The format byte and every protocol-indicator byte carry a presence bitmap for the next group of optional bytes. The parser records the global timing parameters, collects the offered protocol types and counts the historical bytes. When the answer offers any protocol other than type 0, it also checks the final check byte. A done flag or exactly one error flag then latches until reset. From that point further strobes are ignored.

Top module: `atr_parser`

## Requirements
- R1: A first raw byte of 0x3B selects direct convention (`conv_inverse`=0). A first raw byte of 0x03 selects inverse convention (`conv_inverse`=1). In inverse convention each later byte is complemented and bit-reversed before use. Any other first byte sets `err_ts` and stops parsing.
- R2: In the format byte, bits 4, 5, 6 and 7 announce the first-group bytes A, B, C and D, which arrive in that order. Bits 3:0 give the historical byte count, which appears on `hist_count`.
- R3: A group-D byte announces the next group with bits 4 to 7, in the same A, B, C, D order. Its bits 3:0 name a protocol type T, which sets bit T of `proto_offered`.
- R4: When no group-D byte has been received, `proto_offered` reads 0x0001 and no further interface bytes are expected.
- R5: The first-group A byte loads `fi_code` from bits 7:4 and `di_code` from bits 3:0. The defaults are 1 and 1.
- R6: The first-group C byte loads `guard_n`, with default 0. The second-group C byte loads `wi_code`, with default 10. All other A, B and C bytes leave every output unchanged.
- R7: A check byte is expected only if some group-D byte named a type other than 0. If the XOR of all bytes from the format byte through the check byte is zero, `parse_done` sets. Otherwise `err_check` sets. Without a check byte, `parse_done` sets right after the last historical or interface byte.
- R8: If a 33rd byte after the convention byte arrives while the chain still expects bytes, `err_length` sets and parsing stops.
- R9: `parse_done` and the error flags are sticky and mutually exclusive. Once one is set, strobes change no output.
- R10: After a synchronous active-low reset, all outputs hold their defaults: direct convention, FI=1, DI=1, N=0, WI=10, protocols 0x0001, count 0 and no flags. Each output reflects a strobed byte from the clock edge that samples that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Raw received byte, line coding |
| conv_inverse | output | 1 | 1 when inverse convention was detected |
| fi_code | output | 4 | Clock rate conversion code |
| di_code | output | 4 | Bit rate adjustment code |
| guard_n | output | 8 | Extra guard time value |
| wi_code | output | 8 | Work waiting time integer |
| proto_offered | output | 16 | Bitmap of offered protocol types |
| hist_count | output | 4 | Number of historical bytes announced |
| parse_done | output | 1 | Answer parsed without error |
| err_ts | output | 1 | Convention byte invalid |
| err_length | output | 1 | Answer longer than 32 bytes |
| err_check | output | 1 | Check byte mismatch |

## Verification
A wrong pending-byte bitmap or group index makes a later byte land in the wrong field. That shows up as a parameter changing when it should not, or keeping its default, on the edge after the misread byte. A wrong historical countdown or check-required flag moves `parse_done` by at least one cycle, or turns it into `err_check`. A wrong convention register corrupts every decoded parameter from the format byte onward. The bench compares every output against a behavioural model on every clock, so each of these faults is flagged in the cycle it first reaches a port.

// File: rtl/atr_parse_pkg.sv
// Package: shared types for the answer-to-reset parser.
// Assumes byte-wide characters and 4-bit nibble fields.
package atr_parse_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;

    typedef enum logic [2:0] {
        ST_TS, ST_FMT, ST_IFC, ST_HIST, ST_CHK, ST_DONE, ST_FAIL
    } parse_state_t;

    typedef enum logic [3:0] {
        K_NONE, K_TS, K_FMT, K_TA, K_TB, K_TC, K_TD, K_HIST, K_CHK
    } byte_kind_t;
endpackage

// File: rtl/atr_conv_unit.sv
// Convention unit: recognises the two legal convention bytes, stores
// the selected convention and maps every later raw byte to its logical
// value. Assumes ts_take pulses only for the first byte of an answer.
module atr_conv_unit #(
    parameter int unsigned BYTE_W     = 8,
    parameter logic [7:0]  DIRECT_TS  = 8'h3B,
    parameter logic [7:0]  INVERSE_TS = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_take,
    input  logic [BYTE_W-1:0] raw_i,
    output logic              ts_direct_o,
    output logic              ts_inverse_o,
    output logic              inverse_o,
    output logic [BYTE_W-1:0] byte_o
);
    logic              inv_q;
    logic [BYTE_W-1:0] flipped;

    // Purpose: build the complemented, bit-reversed view of the raw byte.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_flip
        assign flipped[i] = ~raw_i[BYTE_W-1-i];
    end

    assign ts_direct_o  = (raw_i == DIRECT_TS[BYTE_W-1:0]);
    assign ts_inverse_o = (raw_i == INVERSE_TS[BYTE_W-1:0]);
    assign inverse_o    = inv_q;
    assign byte_o       = inv_q ? flipped : raw_i;

    // Purpose: latch the convention when the first byte is an inverse marker.
    always_ff @(posedge clk) begin
        if (!rst_n)                      inv_q <= 1'b0;
        else if (ts_take && ts_inverse_o) inv_q <= 1'b1;
    end

    assert_conv_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_q) |-> $past(ts_take));
endmodule

// File: rtl/atr_check_unit.sv
// Check unit: counts the bytes after the convention byte and keeps
// their running XOR. Assumes accept_i pulses once per counted byte and
// never while the count is already at its limit.
module atr_check_unit #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned MAX_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              count_full_o,
    output logic              sum_ok_o
);
    localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] acc_q;

    assign count_full_o = (cnt_q == CNT_W'(MAX_BYTES));
    assign sum_ok_o     = ((acc_q ^ byte_i) == '0);

    // Purpose: advance byte count and running XOR on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (accept_i) begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_q ^ byte_i;
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/atr_chain_fsm.sv
// Chain walker: classifies every strobed byte (convention, format,
// interface A/B/C/D, historical, check). It follows the presence bitmaps,
// counts down historical bytes and raises the terminal flags.
// Assumes byte_i is already convention-decoded.
module atr_chain_fsm
    import atr_parse_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ts_direct_i,
    input  logic              ts_inverse_i,
    input  logic              count_full_i,
    input  logic              sum_ok_i,
    output logic              ts_take_o,
    output logic              accept_o,
    output byte_kind_t        kind_o,
    output logic [1:0]        group_o,
    output logic [NIB_W-1:0]  hist_count_o,
    output logic              done_o,
    output logic              err_ts_o,
    output logic              err_len_o,
    output logic              err_chk_o
);
    localparam int unsigned GRP_W = 4;

    parse_state_t     state_q, state_n;
    logic [GRP_W-1:0] pend_q, pend_n, low_bit;
    logic [NIB_W-1:0] hist_q, hist_n, total_q, total_n;
    logic             tck_q, tck_n;
    logic [1:0]       group_q, group_n;
    byte_kind_t       kind_raw;
    logic             over, set_ts, set_len, set_chk;

    function automatic parse_state_t route(input logic [GRP_W-1:0] p,
                                           input logic [NIB_W-1:0] h,
                                           input logic t);
        if (p != '0)      return ST_IFC;
        else if (h != '0) return ST_HIST;
        else if (t)       return ST_CHK;
        else              return ST_DONE;
    endfunction

    // Purpose: classify the current strobe from the state and pending bitmap.
    always_comb begin
        low_bit  = pend_q & (~pend_q + 1'b1);
        kind_raw = K_NONE;
        if (strobe_i) begin
            case (state_q)
                ST_TS:   kind_raw = K_TS;
                ST_FMT:  kind_raw = K_FMT;
                ST_IFC: begin
                    if (low_bit[0])      kind_raw = K_TA;
                    else if (low_bit[1]) kind_raw = K_TB;
                    else if (low_bit[2]) kind_raw = K_TC;
                    else                 kind_raw = K_TD;
                end
                ST_HIST: kind_raw = K_HIST;
                ST_CHK:  kind_raw = K_CHK;
                default: kind_raw = K_NONE;
            endcase
        end
        over   = count_full_i && (kind_raw != K_NONE) && (kind_raw != K_TS);
        kind_o = over ? K_NONE : kind_raw;
    end

    assign ts_take_o = (kind_o == K_TS);
    assign accept_o  = (kind_o != K_NONE) && (kind_o != K_TS);

    // Purpose: compute next chain bookkeeping and next state.
    always_comb begin
        state_n = state_q;
        pend_n  = pend_q;
        hist_n  = hist_q;
        total_n = total_q;
        tck_n   = tck_q;
        group_n = group_q;
        set_ts  = 1'b0;
        set_len = 1'b0;
        set_chk = 1'b0;
        case (kind_o)
            K_TS: begin
                if (ts_direct_i || ts_inverse_i) state_n = ST_FMT;
                else begin
                    state_n = ST_FAIL;
                    set_ts  = 1'b1;
                end
            end
            K_FMT: begin
                pend_n  = byte_i[BYTE_W-1 -: GRP_W];
                hist_n  = byte_i[NIB_W-1:0];
                total_n = byte_i[NIB_W-1:0];
                state_n = route(pend_n, hist_n, tck_n);
            end
            K_TA, K_TB, K_TC: begin
                pend_n  = pend_q & ~low_bit;
                state_n = route(pend_n, hist_n, tck_n);
            end
            K_TD: begin
                pend_n  = byte_i[BYTE_W-1 -: GRP_W];
                tck_n   = tck_q | (byte_i[NIB_W-1:0] != '0);
                group_n = (group_q == 2'd3) ? 2'd3 : group_q + 2'd1;
                state_n = route(pend_n, hist_n, tck_n);
            end
            K_HIST: begin
                hist_n  = hist_q - 1'b1;
                state_n = route(pend_n, hist_n, tck_n);
            end
            K_CHK: begin
                if (sum_ok_i) state_n = ST_DONE;
                else begin
                    state_n = ST_FAIL;
                    set_chk = 1'b1;
                end
            end
            default: ;
        endcase
        if (over) begin
            state_n = ST_FAIL;
            set_len = 1'b1;
        end
    end

    // Purpose: register chain state, bookkeeping and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_TS;
            pend_q    <= '0;
            hist_q    <= '0;
            total_q   <= '0;
            tck_q     <= 1'b0;
            group_q   <= 2'd1;
            err_ts_o  <= 1'b0;
            err_len_o <= 1'b0;
            err_chk_o <= 1'b0;
        end else begin
            state_q   <= state_n;
            pend_q    <= pend_n;
            hist_q    <= hist_n;
            total_q   <= total_n;
            tck_q     <= tck_n;
            group_q   <= group_n;
            err_ts_o  <= err_ts_o  | set_ts;
            err_len_o <= err_len_o | set_len;
            err_chk_o <= err_chk_o | set_chk;
        end
    end

    assign group_o      = group_q;
    assign hist_count_o = total_q;
    assign done_o       = (state_q == ST_DONE);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_ts_o, err_len_o, err_chk_o}));
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
    assert_ts_error_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ts_o) |-> $past(state_q == ST_TS));
    assert_check_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_chk_o) |-> $past(tck_q));
endmodule

// File: rtl/atr_param_regs.sv
// Parameter registers: capture the global parameters from the first and
// second interface groups and collect the protocol-type bitmap.
// Assumes kind_i and group_i come from the chain walker.
module atr_param_regs
    import atr_parse_pkg::*;
#(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned PROTO_N = 16,
    parameter logic [3:0]  DEF_FI  = 4'd1,
    parameter logic [3:0]  DEF_DI  = 4'd1,
    parameter logic [7:0]  DEF_N   = 8'd0,
    parameter logic [7:0]  DEF_WI  = 8'd10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  byte_kind_t         kind_i,
    input  logic [1:0]         group_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [NIB_W-1:0]   fi_o,
    output logic [NIB_W-1:0]   di_o,
    output logic [BYTE_W-1:0]  n_o,
    output logic [BYTE_W-1:0]  wi_o,
    output logic [PROTO_N-1:0] proto_o
);
    logic [PROTO_N-1:0] map_q, td_hit;
    logic               td_seen_q;

    // Purpose: decode the protocol-type nibble into a one-hot hit vector.
    for (genvar t = 0; t < PROTO_N; t++) begin : g_hit
        assign td_hit[t] = (byte_i[NIB_W-1:0] == NIB_W'(t));
    end

    // Purpose: load parameters from their group-specific positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi_o      <= DEF_FI[NIB_W-1:0];
            di_o      <= DEF_DI[NIB_W-1:0];
            n_o       <= DEF_N[BYTE_W-1:0];
            wi_o      <= DEF_WI[BYTE_W-1:0];
            map_q     <= '0;
            td_seen_q <= 1'b0;
        end else begin
            if (kind_i == K_TA && group_i == 2'd1) begin
                fi_o <= byte_i[BYTE_W-1 -: NIB_W];
                di_o <= byte_i[NIB_W-1:0];
            end
            if (kind_i == K_TC && group_i == 2'd1) n_o  <= byte_i;
            if (kind_i == K_TC && group_i == 2'd2) wi_o <= byte_i;
            if (kind_i == K_TD) begin
                map_q     <= map_q | td_hit;
                td_seen_q <= 1'b1;
            end
        end
    end

    assign proto_o = td_seen_q ? map_q : PROTO_N'(1);

    assert_proto_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        proto_o != '0);
endmodule

// File: rtl/atr_parser.sv
// Top: answer-to-reset byte stream parser. Wires the convention unit,
// chain walker, check unit and parameter registers. Assumes one raw
// byte per rx_valid pulse, starting with the convention byte after reset.
module atr_parser
    import atr_parse_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 32,
    parameter int unsigned PROTO_N   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    output logic                  conv_inverse,
    output logic [NIB_W-1:0]      fi_code,
    output logic [NIB_W-1:0]      di_code,
    output logic [BYTE_W-1:0]     guard_n,
    output logic [BYTE_W-1:0]     wi_code,
    output logic [PROTO_N-1:0]    proto_offered,
    output logic [NIB_W-1:0]      hist_count,
    output logic                  parse_done,
    output logic                  err_ts,
    output logic                  err_length,
    output logic                  err_check
);
    logic              ts_take, ts_direct, ts_inverse;
    logic              accept, count_full, sum_ok;
    logic [BYTE_W-1:0] dec_byte;
    byte_kind_t        kind;
    logic [1:0]        group;

    atr_conv_unit #(.BYTE_W(BYTE_W)) u_conv (
        .clk(clk), .rst_n(rst_n), .ts_take(ts_take), .raw_i(rx_byte),
        .ts_direct_o(ts_direct), .ts_inverse_o(ts_inverse),
        .inverse_o(conv_inverse), .byte_o(dec_byte)
    );

    atr_check_unit #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_check (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .byte_i(dec_byte),
        .count_full_o(count_full), .sum_ok_o(sum_ok)
    );

    atr_chain_fsm #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe_i(rx_valid), .byte_i(dec_byte),
        .ts_direct_i(ts_direct), .ts_inverse_i(ts_inverse),
        .count_full_i(count_full), .sum_ok_i(sum_ok),
        .ts_take_o(ts_take), .accept_o(accept), .kind_o(kind),
        .group_o(group), .hist_count_o(hist_count), .done_o(parse_done),
        .err_ts_o(err_ts), .err_len_o(err_length), .err_chk_o(err_check)
    );

    atr_param_regs #(.BYTE_W(BYTE_W), .NIB_W(NIB_W), .PROTO_N(PROTO_N)) u_params (
        .clk(clk), .rst_n(rst_n), .kind_i(kind), .group_i(group),
        .byte_i(dec_byte), .fi_o(fi_code), .di_o(di_code), .n_o(guard_n),
        .wi_o(wi_code), .proto_o(proto_offered)
    );

    assert_outputs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (parse_done || err_ts || err_length || err_check) |=>
        $stable({fi_code, di_code, guard_n, wi_code, proto_offered, hist_count, conv_inverse}));
endmodule

// File: tb/atr_parser_tb_top.sv
// Bench: behavioural reference model (queues, integers) compared on every clock.
module atr_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        conv_inverse, parse_done, err_ts, err_length, err_check;
    logic [3:0]  fi_code, di_code, hist_count;
    logic [7:0]  guard_n, wi_code;
    logic [15:0] proto_offered;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    // model state: 0 conv,1 format,2 iface,3 hist,4 check,5 done,6 fail
    int m_state, m_group, m_hist_left, m_count;
    int pend[$];
    bit m_tck, m_inv, m_td_seen, m_done, m_ets, m_elen, m_echk;
    int m_fi, m_di, m_n, m_wi, m_hist;
    logic [15:0] m_map;
    logic [7:0]  m_acc;

    atr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .conv_inverse(conv_inverse), .fi_code(fi_code), .di_code(di_code),
        .guard_n(guard_n), .wi_code(wi_code), .proto_offered(proto_offered),
        .hist_count(hist_count), .parse_done(parse_done), .err_ts(err_ts),
        .err_length(err_length), .err_check(err_check)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = !b[7 - i];
        return r;
    endfunction

    task automatic model_reset();
        m_state = 0; m_group = 1; m_hist_left = 0; m_count = 0;
        pend.delete();
        m_tck = 0; m_inv = 0; m_td_seen = 0; m_done = 0;
        m_ets = 0; m_elen = 0; m_echk = 0;
        m_fi = 1; m_di = 1; m_n = 0; m_wi = 10; m_hist = 0;
        m_map = 16'h0; m_acc = 8'h0;
    endtask

    task automatic push_flags(input logic [7:0] b);
        for (int k = 0; k < 4; k++) if (b[4 + k]) pend.push_back(k);
    endtask

    task automatic advance();
        if (pend.size() > 0)   m_state = 2;
        else if (m_hist_left > 0) m_state = 3;
        else if (m_tck)        m_state = 4;
        else begin m_state = 5; m_done = 1; end
    endtask

    task automatic model_apply(input logic [7:0] raw);
        logic [7:0] b;
        int k;
        if (m_state >= 5) return;
        if (m_state == 0) begin
            if (raw == 8'h3B) begin m_inv = 0; m_state = 1; end
            else if (raw == 8'h03) begin m_inv = 1; m_state = 1; end
            else begin m_ets = 1; m_state = 6; end
            return;
        end
        b = m_inv ? flip(raw) : raw;
        if (m_count == 32) begin m_elen = 1; m_state = 6; return; end
        m_count++;
        case (m_state)
            1: begin
                m_hist = b[3:0]; m_hist_left = b[3:0];
                push_flags(b); m_acc ^= b; advance();
            end
            2: begin
                k = pend.pop_front();
                if (k == 0 && m_group == 1) begin m_fi = b[7:4]; m_di = b[3:0]; end
                if (k == 2 && m_group == 1) m_n = b;
                if (k == 2 && m_group == 2) m_wi = b;
                if (k == 3) begin
                    m_td_seen = 1; m_map[b[3:0]] = 1'b1;
                    if (b[3:0] != 0) m_tck = 1;
                    m_group++; push_flags(b);
                end
                m_acc ^= b; advance();
            end
            3: begin m_hist_left--; m_acc ^= b; advance(); end
            4: begin
                if ((m_acc ^ b) == 0) begin m_done = 1; m_state = 5; end
                else begin m_echk = 1; m_state = 6; end
            end
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            chk("R1 conv_inverse", 32'(conv_inverse), 32'(m_inv));
            chk("R1 err_ts", 32'(err_ts), 32'(m_ets));
            chk("R2 hist_count", 32'(hist_count), 32'(m_hist));
            chk("R3 R4 proto_offered", 32'(proto_offered),
                32'(m_td_seen ? m_map : 16'h0001));
            chk("R5 fi_code", 32'(fi_code), 32'(m_fi));
            chk("R5 di_code", 32'(di_code), 32'(m_di));
            chk("R6 guard_n", 32'(guard_n), 32'(m_n));
            chk("R6 wi_code", 32'(wi_code), 32'(m_wi));
            chk("R7 R9 parse_done", 32'(parse_done), 32'(m_done));
            chk("R7 err_check", 32'(err_check), 32'(m_echk));
            chk("R8 err_length", 32'(err_length), 32'(m_elen));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rx_valid = 0; model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send(input logic [7:0] raw);
        @(negedge clk);
        rx_valid = 1; rx_byte = raw; model_apply(raw);
        @(negedge clk);
        rx_valid = 0;
    endtask

    // send logical bytes encoded for the chosen convention, then a check byte
    task automatic send_answer(input bit inv, input logic [7:0] q[$],
                               input bit add_chk, input bit bad_chk);
        logic [7:0] x = 8'h00;
        send(inv ? 8'h03 : 8'h3B);
        foreach (q[i]) begin
            x ^= q[i];
            send(inv ? flip(q[i]) : q[i]);
        end
        if (add_chk) begin
            if (bad_chk) x ^= 8'h5A;
            send(inv ? flip(x) : x);
        end
    endtask

    initial begin
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        model_reset();
        do_reset();
        // R10: defaults after reset are checked by the per-clock compare
        chk("R10 reset flags", 32'({parse_done, err_ts, err_length, err_check}), 32'h0);

        // R2 R4 R7: minimal direct answer, then strobes ignored (R9)
        q = '{8'h00};
        send_answer(0, q, 0, 0);
        send(8'h77); send(8'hC5);
        chk("R9 done held", 32'(parse_done), 32'h1);

        // R5 R6: first-group A and C bytes
        do_reset();
        q = '{8'h50, 8'h96, 8'h05};
        send_answer(0, q, 0, 0);

        // R3 R6 R7: protocol 1 offered, second-group C, two historical bytes, good check
        do_reset();
        q = '{8'h82, 8'h41, 8'h20, 8'hAA, 8'hBB};
        send_answer(0, q, 1, 0);

        // R7: same answer, corrupted check byte
        do_reset();
        send_answer(0, q, 1, 1);
        send(8'h00);
        chk("R7 err_check set", 32'(err_check), 32'h1);

        // R1: inverse convention with A byte and one historical byte
        do_reset();
        q = '{8'h11, 8'h13, 8'h55};
        send_answer(1, q, 0, 0);
        chk("R1 inverse decode fi", 32'(fi_code), 32'h1);

        // R1 R9: bad convention byte, later strobes ignored
        do_reset();
        send(8'h3F); send(8'h10); send(8'h96);
        chk("R1 err_ts set", 32'(err_ts), 32'h1);

        // R8 R6 R3: long chain, ignored later-group A/B bytes, overflow
        do_reset();
        q = '{8'h8F, 8'hF1};
        for (int g = 0; g < 3; g++) begin
            q.push_back(8'h3C); q.push_back(8'h44); q.push_back(8'h21 + 8'(g));
            q.push_back(8'hF1 + 8'(g));
        end
        q.push_back(8'h3C); q.push_back(8'h44); q.push_back(8'h21); q.push_back(8'h05);
        for (int h = 0; h < 15; h++) q.push_back(8'(h));
        send_answer(0, q, 1, 0);
        chk("R8 err_length set", 32'(err_length), 32'h1);

        // R2 R3: inverse, two protocol types, with check
        do_reset();
        q = '{8'h90, 8'h18, 8'h8E, 8'h00};
        send_answer(1, q, 1, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule